// File: doc/BRIEF.md
# Fast Startup Wake-Up Detector

This block decides when a device may drop into its low-power wait state and produces the request that brings it back out. Sixteen external wake pins are watched. Each pin has its own enable bit and its own active level. Three internal alarm sources are watched as well, each with its own enable bit: the real-time clock, the real-time timer and the USB controller. Any enabled source at its active level raises a fast startup request. This request is built from gates alone, so it also works while the clock is stopped.

Software sets up two write-only configuration words. The mode word holds the pin enables, the alarm enables and the low-power bit. The polarity word holds one active-level bit per pin. A wait-for-event strobe puts the block into wait only while the low-power bit is set. If a source is already active when the strobe arrives, the block stays awake and records the attempt in a sticky blocked flag. While the block waits, the first fast startup event raises the oscillator restart request in the same cycle and ends the wait at the next edge. The restart request then stays high until the caller acknowledges it.

Top module: `fast_wake_ctl`

## Requirements
- R1: After reset, `in_wait`, `osc_restart_req`, `entry_blocked` and `wake_req` are all 0. All enables are 0, all polarity bits are 0 and the low-power bit is 0.
- R2: A configuration write with `cfg_addr`=1 loads the polarity word from `cfg_wdata[15:0]`. Bit i=1 makes pin i active high. Bit i=0 makes it active low.
- R3: An enabled pin at its active level drives `wake_req` to 1 in the same cycle, with no clock edge needed.
- R4: A pin whose enable bit is 0 has no effect on `wake_req`. The same holds for an alarm whose enable bit is 0.
- R5: A configuration write with `cfg_addr`=0 loads the mode word. Bits [15:0] are the pin enables. Bit 16 enables the RTC alarm, bit 17 the RTT alarm and bit 18 the USB alarm. Each enabled alarm input at 1 drives `wake_req` to 1.
- R6: A `wfe_strobe` with the low-power bit (mode bit 19) at 1, no active source and the block awake sets `in_wait` at the next edge.
- R7: A `wfe_strobe` while the low-power bit is 0 has no effect. `in_wait` and `entry_blocked` keep their values.
- R8: A `wfe_strobe` with the low-power bit at 1 while `wake_req` is 1 leaves `in_wait` at 0 and sets `entry_blocked`. The flag stays set until the next mode-word write clears it. A new blocked attempt in the same cycle as that write wins.
- R9: While `in_wait` is 1, a `wake_req` of 1 drives `osc_restart_req` to 1 in the same cycle and clears `in_wait` at the next edge.
- R10: After a wake, `osc_restart_req` stays 1 until `wake_ack` is seen at an edge. It reads 0 after that edge. A new wake in the same cycle as the acknowledge wins.
- R11: A `wfe_strobe` while `in_wait` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration and wait-state registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Selects the word to write: 0 = mode, 1 = polarity |
| cfg_wdata | input | 20 | Configuration write data |
| wake_pin | input | 16 | External wake-up inputs |
| alarm_in | input | 3 | Internal alarms: bit 0 RTC, bit 1 RTT, bit 2 USB |
| wfe_strobe | input | 1 | Wait-for-event strobe, one cycle per event |
| wake_ack | input | 1 | Acknowledges and clears the restart request |
| wake_req | output | 1 | Fast startup request, built from gates alone |
| in_wait | output | 1 | The block is in wait mode |
| osc_restart_req | output | 1 | Oscillator restart request |
| entry_blocked | output | 1 | Sticky flag: a wait entry was refused |

## Verification
`wake_req` responds within the same cycle, so the bench checks it one nanosecond after it changes a pin, alarm or enable, with no clock edge in between. Wait entry, entry blocking, leaving wait and the clearing of the restart request each take effect at the first rising edge after the stimulus. The bench drives every stimulus on a falling edge and reads the result on the next falling edge, which is exactly one register stage later. The same-cycle restart on a wake is sampled before that edge, which shows that `osc_restart_req` rises while `in_wait` still reads 1.

// File: rtl/fw_pkg.sv
package fw_pkg;

   typedef enum logic {
      FW_SEL_MODE = 1'b0,
      FW_SEL_POL  = 1'b1
   } fw_sel_e;

   // position of the low-power bit in the mode word
   function automatic int fw_lpm_bit(input int n_wake, input int n_alarm);
      return n_wake + n_alarm;
   endfunction

endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs
   import fw_pkg::*;
#(
   parameter int N_WAKE  = 16,
   parameter int N_ALARM = 3,
   localparam int CFG_W  = N_WAKE + N_ALARM + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic               addr,
   input  logic [CFG_W-1:0]   wdata,
   output logic [N_WAKE-1:0]  wake_en,
   output logic [N_ALARM-1:0] alarm_en,
   output logic [N_WAKE-1:0]  pol,
   output logic               lpm,
   output logic               mode_wr
);

   localparam int LPM_BIT = fw_lpm_bit(N_WAKE, N_ALARM);

   fw_sel_e sel;
   assign sel     = fw_sel_e'(addr);
   assign mode_wr = we && (sel == FW_SEL_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_en  <= '0;
         alarm_en <= '0;
         lpm      <= 1'b0;
         pol      <= '0;
      end else if (we) begin
         if (sel == FW_SEL_MODE) begin
            wake_en  <= wdata[N_WAKE-1:0];
            alarm_en <= wdata[LPM_BIT-1:N_WAKE];
            lpm      <= wdata[LPM_BIT];
         end else begin
            pol      <= wdata[N_WAKE-1:0];
         end
      end
   end

endmodule

// File: rtl/fw_src_detect.sv
module fw_src_detect #(
   parameter int N_WAKE  = 16,
   parameter int N_ALARM = 3
) (
   input  logic [N_WAKE-1:0]  pin,
   input  logic [N_WAKE-1:0]  pin_en,
   input  logic [N_WAKE-1:0]  pol,
   input  logic [N_ALARM-1:0] alarm,
   input  logic [N_ALARM-1:0] alarm_en,
   output logic               hit
);

   logic [N_WAKE-1:0]  pin_hit;
   logic [N_ALARM-1:0] alarm_hit;

   // one level comparator per wake pin
   for (genvar i = 0; i < N_WAKE; i++) begin : g_pin
      assign pin_hit[i] = pin_en[i] && (pin[i] == pol[i]);
   end

   for (genvar j = 0; j < N_ALARM; j++) begin : g_alarm
      assign alarm_hit[j] = alarm_en[j] && alarm[j];
   end

   assign hit = (|pin_hit) || (|alarm_hit);

endmodule

// File: rtl/fw_wait_fsm.sv
module fw_wait_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic wfe,
   input  logic lpm,
   input  logic hit,
   input  logic ack,
   input  logic clr_blocked,
   output logic waiting,
   output logic restart,
   output logic blocked
);

   logic restart_q;
   logic try_enter;
   logic wake_now;

   assign try_enter = wfe && lpm && !waiting;
   assign wake_now  = waiting && hit;
   // the gate path raises the request before any edge
   assign restart   = restart_q || wake_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting   <= 1'b0;
         restart_q <= 1'b0;
         blocked   <= 1'b0;
      end else begin
         if (wake_now)
            waiting <= 1'b0;
         else if (try_enter && !hit)
            waiting <= 1'b1;

         if (wake_now)
            restart_q <= 1'b1;
         else if (ack)
            restart_q <= 1'b0;

         if (try_enter && hit)
            blocked <= 1'b1;
         else if (clr_blocked)
            blocked <= 1'b0;
      end
   end

endmodule

// File: rtl/fast_wake_ctl.sv
module fast_wake_ctl #(
   parameter int N_WAKE  = 16,
   parameter int N_ALARM = 3,
   localparam int CFG_W  = N_WAKE + N_ALARM + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_addr,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic [N_WAKE-1:0]  wake_pin,
   input  logic [N_ALARM-1:0] alarm_in,
   input  logic               wfe_strobe,
   input  logic               wake_ack,
   output logic               wake_req,
   output logic               in_wait,
   output logic               osc_restart_req,
   output logic               entry_blocked
);

   if (N_WAKE < 1 || N_WAKE > 32) begin : g_bad_wake
      $error("fast_wake_ctl: N_WAKE must lie in 1..32");
   end
   if (N_ALARM < 1 || N_ALARM > 8) begin : g_bad_alarm
      $error("fast_wake_ctl: N_ALARM must lie in 1..8");
   end

   logic [N_WAKE-1:0]  pin_en_q;
   logic [N_ALARM-1:0] alarm_en_q;
   logic [N_WAKE-1:0]  pol_q;
   logic               lpm_q;
   logic               mode_wr;

   fw_cfg_regs #(.N_WAKE(N_WAKE), .N_ALARM(N_ALARM)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .wake_en  (pin_en_q),
      .alarm_en (alarm_en_q),
      .pol      (pol_q),
      .lpm      (lpm_q),
      .mode_wr  (mode_wr)
   );

   fw_src_detect #(.N_WAKE(N_WAKE), .N_ALARM(N_ALARM)) u_det (
      .pin      (wake_pin),
      .pin_en   (pin_en_q),
      .pol      (pol_q),
      .alarm    (alarm_in),
      .alarm_en (alarm_en_q),
      .hit      (wake_req)
   );

   fw_wait_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wfe         (wfe_strobe),
      .lpm         (lpm_q),
      .hit         (wake_req),
      .ack         (wake_ack),
      .clr_blocked (mode_wr),
      .waiting     (in_wait),
      .restart     (osc_restart_req),
      .blocked     (entry_blocked)
   );

endmodule

// File: rtl/fw_checks.sv
module fw_checks (
   input logic clk,
   input logic rst_n,
   input logic cfg_we,
   input logic lpm,
   input logic wfe,
   input logic hit,
   input logic ack,
   input logic waiting,
   input logic restart,
   input logic blocked
);

   a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe && lpm && !waiting && !hit) |=> waiting);

   a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe && !lpm && !waiting && !cfg_we) |=> (!waiting && $stable(blocked)));

   a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
      (wfe && lpm && !waiting && hit) |=> (blocked && !waiting));

   a_r9_restart_now: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && hit) |-> restart);

   a_r9_leave: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && hit) |=> !waiting);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !ack) |=> restart);

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && ack && !waiting && !wfe) |=> !restart);

   a_r11_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !hit) |=> (waiting && $stable(blocked)));

endmodule

bind fast_wake_ctl fw_checks u_fw_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_we  (cfg_we),
   .lpm     (lpm_q),
   .wfe     (wfe_strobe),
   .hit     (wake_req),
   .ack     (wake_ack),
   .waiting (in_wait),
   .restart (osc_restart_req),
   .blocked (entry_blocked)
);

// File: tb/tb_fast_wake_ctl.sv
`timescale 1ns/1ps
module tb_fast_wake_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_addr = 1'b0;
   logic [19:0] cfg_wdata = '0;
   logic [15:0] wake_pin = '0;
   logic [2:0]  alarm_in = '0;
   logic        wfe_strobe = 1'b0;
   logic        wake_ack = 1'b0;
   logic        wake_req, in_wait, osc_restart_req, entry_blocked;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fast_wake_ctl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .wake_pin(wake_pin), .alarm_in(alarm_in),
      .wfe_strobe(wfe_strobe), .wake_ack(wake_ack), .wake_req(wake_req),
      .in_wait(in_wait), .osc_restart_req(osc_restart_req),
      .entry_blocked(entry_blocked)
   );

   task automatic check(input bit got, input bit exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", req, got, exp);
      end
   endtask

   function automatic logic [19:0] mode_word(input logic [15:0] en,
                                             input logic [2:0] alm,
                                             input logic lpm);
      return {lpm, alm, en};
   endfunction

   task automatic cfg_write(input logic a, input logic [19:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wfe_pulse();
      @(negedge clk);
      wfe_strobe = 1'b1;
      @(negedge clk);
      wfe_strobe = 1'b0;
   endtask

   task automatic t_reset();
      check(in_wait, 1'b0, "R1 in_wait");
      check(osc_restart_req, 1'b0, "R1 restart");
      check(entry_blocked, 1'b0, "R1 blocked");
      wake_pin = 16'h0000; #1;
      check(wake_req, 1'b0, "R1 wake_req with all pins low");
   endtask

   task automatic t_polarity();
      cfg_write(1'b0, mode_word(16'h8008, 3'b000, 1'b0));
      cfg_write(1'b1, 20'h00008);
      wake_pin = 16'h8008; #1;
      check(wake_req, 1'b1, "R2/R3 pin3 active high, pin15 low-active held high");
      wake_pin = 16'h8000; #1;
      check(wake_req, 1'b0, "R2 pin3 low with high polarity");
      wake_pin = 16'h0008; #1;
      check(wake_req, 1'b1, "R2/R3 pin15 active low");
      cfg_write(1'b1, 20'h00000);
      wake_pin = 16'h8000; #1;
      check(wake_req, 1'b1, "R2 pin3 active low after polarity change");
      wake_pin = 16'h8008;
   endtask

   task automatic t_disabled();
      cfg_write(1'b0, mode_word(16'h0008, 3'b000, 1'b0));
      cfg_write(1'b1, 20'h00008);
      wake_pin = 16'h0008 | 16'h0000; #1;
      check(wake_req, 1'b1, "R3 enabled pin3 high");
      wake_pin = 16'hfff0; alarm_in = 3'b111; #1;
      check(wake_req, 1'b0, "R4 disabled pins and alarms ignored");
      wake_pin = 16'h0000; #1;
      check(wake_req, 1'b0, "R4 disabled pins low with low polarity ignored");
      alarm_in = 3'b000;
   endtask

   task automatic t_alarms();
      wake_pin = 16'h0000;
      for (int k = 0; k < 3; k++) begin
         cfg_write(1'b0, mode_word(16'h0000, 3'b001 << k, 1'b0));
         alarm_in = ~(3'b001 << k); #1;
         check(wake_req, 1'b0, $sformatf("R5 alarm %0d other alarms only", k));
         alarm_in = 3'b001 << k; #1;
         check(wake_req, 1'b1, $sformatf("R5 alarm %0d enabled", k));
         alarm_in = 3'b000;
      end
   endtask

   task automatic t_lpm_off();
      cfg_write(1'b0, mode_word(16'h0001, 3'b000, 1'b0));
      wake_pin = 16'h0000; #1;
      check(wake_req, 1'b1, "R7 setup source active");
      wfe_pulse();
      check(in_wait, 1'b0, "R7 wfe with lpm 0 no wait");
      check(entry_blocked, 1'b0, "R7 wfe with lpm 0 no block");
      wake_pin = 16'h0001; #1;
      wfe_pulse();
      check(in_wait, 1'b0, "R7 idle source lpm 0 no wait");
   endtask

   task automatic t_enter_wake();
      cfg_write(1'b1, 20'h00000);
      cfg_write(1'b0, mode_word(16'h0001, 3'b000, 1'b1));
      wake_pin = 16'h0001;
      wfe_pulse();
      check(in_wait, 1'b1, "R6 enter wait");
      check(osc_restart_req, 1'b0, "R6 no restart on entry");
      wfe_pulse();
      check(in_wait, 1'b1, "R11 second wfe keeps wait");
      check(entry_blocked, 1'b0, "R11 second wfe no block");
      wake_pin = 16'h0000; #1;
      check(osc_restart_req, 1'b1, "R9 restart raised before edge");
      check(in_wait, 1'b1, "R9 still waiting before edge");
      @(negedge clk);
      check(in_wait, 1'b0, "R9 wait left after edge");
      wake_pin = 16'h0001;
      @(negedge clk); @(negedge clk);
      check(osc_restart_req, 1'b1, "R10 restart held without ack");
      wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0;
      check(osc_restart_req, 1'b0, "R10 restart cleared by ack");
   endtask

   task automatic t_ack_conflict();
      wfe_pulse();
      check(in_wait, 1'b1, "R6 re-enter wait");
      wake_pin = 16'h0000; wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0; wake_pin = 16'h0001;
      check(osc_restart_req, 1'b1, "R10 wake beats ack");
      wake_ack = 1'b1;
      @(negedge clk);
      wake_ack = 1'b0;
      check(osc_restart_req, 1'b0, "R10 later ack clears");
   endtask

   task automatic t_blocked();
      wake_pin = 16'h0000; #1;
      wfe_pulse();
      check(in_wait, 1'b0, "R8 no entry with active source");
      check(entry_blocked, 1'b1, "R8 blocked set");
      wake_pin = 16'h0001;
      @(negedge clk); @(negedge clk);
      check(entry_blocked, 1'b1, "R8 blocked sticky");
      cfg_write(1'b1, 20'h00000);
      check(entry_blocked, 1'b1, "R8 polarity write keeps blocked");
      cfg_write(1'b0, mode_word(16'h0001, 3'b000, 1'b1));
      check(entry_blocked, 1'b0, "R8 mode write clears blocked");
      wake_pin = 16'h0000;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 1'b0;
      cfg_wdata = mode_word(16'h0001, 3'b000, 1'b1);
      wfe_strobe = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; wfe_strobe = 1'b0;
      check(entry_blocked, 1'b1, "R8 new block beats clear");
      wake_pin = 16'h0001;
   endtask

   initial begin
      #20;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_polarity();
      t_disabled();
      t_alarms();
      t_lpm_off();
      t_enter_wake();
      t_ack_conflict();
      t_blocked();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule